// File: doc/BRIEF.md
# Mid-Line Sync Blanker for Composite Sync

This block cleans a digitized composite sync stream so that only line-start sync pulses reach the horizontal timing logic. Composite sync carries extra narrow pulses at half-line spacing around the vertical interval. These are the equalizing pulses and the notches cut into the long vertical pulse. Any sync falling edge that lands in the middle of a line is removed. Every edge near the line boundary is kept with its original width.

The block runs on a fast sample clock. It takes the phase of the line from a square wave at four times the line rate, supplied by an external phase-locked loop and treated here as a sampled input. Each rising edge of that wave moves a quarter counter one step. Quarters 0 and 3 border the line start and form the open window. Quarters 1 and 2 make up the blanked middle of the line. The first accepted sync edge after reset sets the counter to quarter 0. A falling edge on the line reference input sets it to quarter 0 again at any time. The three inputs each pass through a two-stage synchronizer before any decision is made.

Top module: `csync_midline_blanker`

## Requirements
- R1: While reset is held, and afterwards until the first sync falling edge is accepted, `hsync_n` is 1 (inactive).
- R2: Each input goes through a two-stage synchronizer and the output is registered, so a change on `csync_n` shows on `hsync_n` exactly 3 `clk` cycles later.
- R3: The first `csync_n` falling edge after reset is accepted whatever its phase, and it sets the quarter counter to 0.
- R4: Each rising edge of `quad_clk` moves the quarter counter from q to (q+1) mod 4.
- R5: A `csync_n` falling edge seen while the counter is in quarter 1 or 2 is deleted, and `hsync_n` stays 1 for the whole of that pulse.
- R6: A `csync_n` falling edge seen in quarter 0 or quarter 3 drives `hsync_n` low (active low, the same polarity as the input). The output pulse has the same width as the input pulse.
- R7: A rising edge on `csync_n` always returns `hsync_n` to 1 on the same delayed cycle, including in the middle of a long vertical pulse.
- R8: A falling edge on `line_ref_n` sets the quarter counter to 0 and counts as lock. It has priority over a `quad_clk` rising edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Digitized composite sync, active low |
| quad_clk | input | 1 | Square wave at four times the line rate, phase-coherent with sync |
| line_ref_n | input | 1 | Line-phase reference; its falling edge marks quarter 0 |
| hsync_n | output | 1 | Cleaned line sync, active low |

## Verification
Some checks hold on every cycle, and the assertions cover these. Before lock the output stays inactive. The first edge gives lock at quarter 0. The counter moves one step per quad-clock edge, or is pulled back to 0 by the reference. An edge in a middle quarter never pulls the output low, and an edge in a border quarter always does. A high input always releases the output. Other behaviour can only be seen across whole lines, and only the bench scenarios show it. This covers the exact three-cycle latency and width preservation. It covers the equalizing and notched vertical patterns. It covers a sweep that puts a sync edge at every position in a line. It also covers a start on a wrong phase, where lines are lost until the reference restores the phase.

// File: rtl/csync_blank_pkg.sv
package csync_blank_pkg;

  typedef int unsigned uint_t;

  // Quarter that follows q in a line split into nq parts.
  function automatic uint_t quarter_next(uint_t q, uint_t nq);
    return (q + 1) % nq;
  endfunction

  // A quarter is open when it borders the line start: the first one or the last one.
  function automatic logic quarter_open(uint_t q, uint_t nq);
    return (q == 0) || (q == nq - 1);
  endfunction

  // Next value of the active-low output register.
  function automatic logic blank_next(logic cur, logic start_ok, logic level_hi);
    if (start_ok)
      return 1'b0;
    else if (level_hi)
      return 1'b1;
    else
      return cur;
  endfunction

endpackage

// File: rtl/csync_blank_sync.sv
module csync_blank_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stg <= {STAGES{RST_VAL}};
    else
      stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/csync_blank_edge.sv
module csync_blank_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RISE    = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] evt
);
  logic [W-1:0] dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dly <= RST_VAL;
    else
      dly <= d;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RISE[i]) begin : g_rise
      assign evt[i] = d[i] & ~dly[i];
    end else begin : g_fall
      assign evt[i] = ~d[i] & dly[i];
    end
  end
endmodule

// File: rtl/csync_blank_quarter.sv
module csync_blank_quarter
  import csync_blank_pkg::*;
#(
  parameter int NQ = 4,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_fall,
  input  logic          quad_rise,
  input  logic          ref_fall,
  output logic [QW-1:0] phase_q,
  output logic          locked
);
  logic first_align;
  assign first_align = sync_fall & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      locked  <= 1'b0;
    end else if (ref_fall || first_align) begin
      phase_q <= '0;
      locked  <= 1'b1;
    end else if (quad_rise) begin
      phase_q <= QW'(quarter_next(uint_t'(phase_q), uint_t'(NQ)));
    end
  end
endmodule

// File: rtl/csync_blank_gate.sv
module csync_blank_gate
  import csync_blank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_hi,
  input  logic sync_fall,
  input  logic pass_ok,
  output logic out_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_n <= 1'b1;
    else
      out_n <= blank_next(out_n, sync_fall & pass_ok, level_hi);
  end
endmodule

// File: rtl/csync_midline_blanker.sv
module csync_midline_blanker
  import csync_blank_pkg::*;
#(
  parameter int NQ          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  input  logic quad_clk,
  input  logic line_ref_n,
  output logic hsync_n
);
  localparam int QW = $clog2(NQ);
  // bit 0 csync_n, bit 1 quad_clk, bit 2 line_ref_n
  localparam logic [2:0] IDLE_LVL = 3'b101;
  localparam logic [2:0] EDGE_POL = 3'b010;

  logic [2:0]    raw_in;
  logic [2:0]    sync_in;
  logic [2:0]    edge_evt;
  logic          sync_csync;
  logic          fall_evt;
  logic          quad_rise;
  logic          ref_fall;
  logic [QW-1:0] phase_q;
  logic          locked;
  logic          pass_ok;

  assign raw_in = {line_ref_n, quad_clk, csync_n};

  csync_blank_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  csync_blank_edge #(
    .W(3), .RISE(EDGE_POL), .RST_VAL(IDLE_LVL)
  ) u_edge (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .evt(edge_evt)
  );

  assign sync_csync = sync_in[0];
  assign fall_evt   = edge_evt[0];
  assign quad_rise  = edge_evt[1];
  assign ref_fall   = edge_evt[2];

  csync_blank_quarter #(.NQ(NQ)) u_quarter (
    .clk(clk), .rst_n(rst_n),
    .sync_fall(fall_evt), .quad_rise(quad_rise), .ref_fall(ref_fall),
    .phase_q(phase_q), .locked(locked)
  );

  assign pass_ok = ~locked | quarter_open(uint_t'(phase_q), uint_t'(NQ));

  csync_blank_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .level_hi(sync_csync), .sync_fall(fall_evt), .pass_ok(pass_ok),
    .out_n(hsync_n)
  );
endmodule

// File: rtl/csync_midline_blanker_chk.sv
module csync_midline_blanker_chk #(
  parameter int NQ = 4,
  localparam int QW = $clog2(NQ)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_csync,
  input logic          fall_evt,
  input logic          quad_rise,
  input logic          ref_fall,
  input logic [QW-1:0] phase_q,
  input logic          locked,
  input logic          hsync_n
);
  logic mid_q;
  assign mid_q = (phase_q != '0) && (phase_q != QW'(NQ - 1));

  a_r1_idle_before_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> hsync_n);

  a_r3_first_edge_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && fall_evt) |=> (locked && phase_q == '0 && !hsync_n));

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && quad_rise && !ref_fall) |=> (phase_q == QW'($past(phase_q) + 1'b1)));

  a_r5_mid_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && fall_evt && mid_q) |=> hsync_n);

  a_r6_border_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && fall_evt && !mid_q) |=> !hsync_n);

  a_r6_no_spurious_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> $past(fall_evt));

  a_r7_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
    sync_csync |=> hsync_n);

  a_r8_ref_realigns: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fall |=> (locked && phase_q == '0));
endmodule

bind csync_midline_blanker csync_midline_blanker_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_csync(sync_csync), .fall_evt(fall_evt),
  .quad_rise(quad_rise), .ref_fall(ref_fall), .phase_q(phase_q),
  .locked(locked), .hsync_n(hsync_n)
);

// File: tb/csync_midline_blanker_test.sv
module csync_midline_blanker_test;
  localparam int LINE = 64;   // clk cycles per line
  localparam int QTR  = 16;   // clk cycles per quad_clk period

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, csync_n, quad_clk, line_ref_n;
  logic hsync_n;

  csync_midline_blanker uut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .quad_clk(quad_clk),
    .line_ref_n(line_ref_n), .hsync_n(hsync_n)
  );

  int checks = 0;
  int fails  = 0;
  int g;
  bit m_prev_c, m_prev_h, m_prev_r, m_acc, m_lock;
  int m_q;
  bit pipe1, pipe2, pipe3;

  task automatic check(logic got, logic exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, g, got, exp);
    end
  endtask

  // Input patterns; p is the position in the line, the return value is csync_n.
  function automatic bit pat(int mode, int line, int p);
    case (mode)
      0: return !(p < 5);                                  // plain line sync
      1: return !((p % (LINE/2)) < 2);                     // equalizing, half-line
      2: return (p >= 26 && p < 32) || (p >= 58);          // notched vertical pulse
      3: return !(p >= line && p < line + 3);              // edge-position sweep
      default: return (line == 0) ? !(p >= 32 && p < 36) : !(p < 5);
    endcase
  endfunction

  task automatic step(bit c, bit r, string tag);
    bit h, fall, hr, rf, e;
    @(posedge clk);
    #1;
    h = (g % QTR) < (QTR / 2);
    csync_n = c; quad_clk = h; line_ref_n = r;
    fall = m_prev_c && !c;
    hr   = h && !m_prev_h;
    rf   = m_prev_r && !r;
    if (fall) m_acc = !m_lock || (m_q == 0) || (m_q == 3);
    if (rf) begin
      m_q = 0; m_lock = 1;
    end else if (fall && !m_lock) begin
      m_q = 0; m_lock = 1;
    end else if (hr) begin
      m_q = (m_q + 1) % 4;
    end
    e = c ? 1'b1 : !m_acc;
    m_prev_c = c; m_prev_h = h; m_prev_r = r;
    @(negedge clk);
    // R2: output reflects the input three cycles back
    check(hsync_n, pipe3, tag);
    pipe3 = pipe2; pipe2 = pipe1; pipe1 = e;
    g++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; csync_n = 1'b1; quad_clk = 1'b0; line_ref_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(hsync_n, 1'b1, "R1 reset");
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    m_prev_c = 1; m_prev_h = 0; m_prev_r = 1;
    m_acc = 0; m_lock = 0; m_q = 0;
    pipe1 = 1; pipe2 = 1; pipe3 = 1;
    g = 0;
  endtask

  task automatic run(int mode, int nlines, int ref_line, string tag);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int p = 0; p < LINE; p++) begin
        step(pat(mode, ln, p), !(ln == ref_line && (p == 4 || p == 5)), tag);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    g = 0;
    do_reset();
    run(0, 4, -1, "R2 R3 R6 line sync");
    run(1, 4, -1, "R5 equalizing");
    run(2, 4, -1, "R5 R7 notched vertical");
    run(3, LINE, -1, "R4 R5 R6 sweep");
    run(0, 2, -1, "R6 after sweep");
    do_reset();
    check(hsync_n, 1'b1, "R1 idle after reset");
    run(4, 6, 3, "R3 R8 wrong phase then reference");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule